// File: doc/BRIEF.md
# Branch Destination Code Cache

This block keeps the opening code bytes of the most recent branch destinations so that a prefetch queue can be refilled at once after a jump, without waiting for slow program memory. Each branch presents its 16-bit destination. All stored destinations are compared with it in parallel. On a match, the block returns the whole stored code block and the number of valid bytes in it, in the same cycle, for one bulk transfer into the queue.

On a miss, the block claims a slot for the new destination. It then records the code bytes that memory returns for that destination, in order, through a fill port, up to the block size. A later branch ends any fill that is still running. A runtime enable input turns the cache off. While it is off, the cache reports no hits and forgets every stored destination.

Top module: `branch_target_cache`

## Requirements
- R1: After reset no slot is valid. With no branch strobe, `hit` is 0, `hit_count` is 0 and `hit_data` is 0. The first branch after reset misses.
- R2: While enabled, a branch strobe whose target matches no valid slot gives `hit`=0 in that cycle and stores the target. A later branch to the same target gives `hit`=1 in its own cycle, combinationally.
- R3: After a miss, each `fill_valid` cycle without a branch strobe stores `fill_byte` as the next byte of the new slot. The k-th captured byte (k from 0) appears on `hit_data[8k+7:8k]`, and `hit_count` equals the number of bytes captured.
- R4: A slot holds at most 6 bytes. Fill bytes offered after the sixth are ignored, and `hit_count` stays 6.
- R5: Any branch strobe ends a running fill. Fill bytes that follow it do not reach the interrupted slot, which keeps only the bytes it already captured.
- R6: All four slots are searched at once. Four distinct stored targets each hit, and every hit returns the data of its own target.
- R7: On a miss, the slot replaced is the lowest-indexed invalid slot if one exists. Otherwise it is the least recently used slot. Hits and allocations both count as a use.
- R8: While `enable` is 0, `hit` stays 0 and every slot is invalidated. After `enable` returns to 1, previously stored targets miss.
- R9: `fill_valid` has no effect when no fill is running. It also has no effect in a cycle that carries a branch strobe.
- R10: Byte lanes at or above `hit_count` read as 0 on a hit. All outputs read 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Cache on (1) or off and flushed (0) |
| br_valid | input | 1 | Branch strobe |
| br_target | input | 16 | Branch destination address |
| fill_valid | input | 1 | A code byte fetched from memory is present |
| fill_byte | input | 8 | Code byte fetched from memory |
| hit | output | 1 | Branch target found in the cache |
| hit_count | output | 3 | Number of valid bytes in `hit_data` |
| hit_data | output | 48 | Stored code block, byte 0 in the low lanes |

## Verification
The bench builds the block with its default parameters: four slots, six bytes per slot and a 16-bit address. With four slots, a fifth distinct target forces an eviction, so the choice of victim and the effect of hits on recency can be seen at the ports. With six bytes per slot, an eight-byte fill burst runs past the slot limit, and a three-byte fill cut off by a branch leaves lanes that must read zero.

// File: rtl/btc_pkg.sv
package btc_pkg;
    typedef enum logic {FILL_IDLE = 1'b0, FILL_BUSY = 1'b1} fill_st_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/btc_match.sv
module btc_match #(
    parameter int N    = 4,
    parameter int AW   = 16,
    parameter int IW   = 2
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         match,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    always_comb begin
        match = '0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            match[i] = valid[i] && (tags[i] == key);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
        any = |match;
    end
endmodule

// File: rtl/btc_lru.sv
module btc_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    input  logic [N-1:0]  valid,
    output logic [IW-1:0] victim
);
    typedef struct packed {
        logic [N-1:0][IW-1:0] rank;
    } lru_t;

    lru_t s_d, s_q;
    logic found;
    logic [N-1:0][N-1:0] rank_eq;

    always_comb begin
        s_d    = s_q;
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                victim = IW'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < N; i++) begin
                if (s_q.rank[i] == IW'(N - 1)) victim = IW'(i);
            end
        end
        if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx) s_d.rank[i] = '0;
                else if (s_q.rank[i] < s_q.rank[touch_idx]) s_d.rank[i] = s_q.rank[i] + IW'(1);
            end
        end
        for (int r = 0; r < N; r++) begin
            for (int i = 0; i < N; i++) begin
                rank_eq[r][i] = (s_q.rank[i] == IW'(r));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) s_q.rank[i] <= IW'(i);
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_perm
        // R7
        rank_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(rank_eq[r]) == 1);
    end
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
    import btc_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    parameter int BYTES   = 6,
    parameter int DATA_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        enable,
    input  logic                        br_valid,
    input  logic [ADDR_W-1:0]           br_target,
    input  logic                        fill_valid,
    input  logic [DATA_W-1:0]           fill_byte,
    output logic                        hit,
    output logic [$clog2(BYTES+1)-1:0]  hit_count,
    output logic [BYTES*DATA_W-1:0]     hit_data
);
    localparam int IW = idx_w(ENTRIES);
    localparam int CW = $clog2(BYTES + 1);

    typedef struct packed {
        logic [ENTRIES-1:0]                         valid;
        logic [ENTRIES-1:0][ADDR_W-1:0]             tag;
        logic [ENTRIES-1:0][CW-1:0]                 cnt;
        logic [ENTRIES-1:0][BYTES-1:0][DATA_W-1:0]  data;
        fill_st_e                                   fst;
        logic [IW-1:0]                              fidx;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0] match_vec;
    logic               any_match;
    logic [IW-1:0]      match_idx;
    logic [IW-1:0]      victim_idx;
    logic               lookup;
    logic               touch;
    logic [IW-1:0]      touch_idx;
    logic [CW-1:0]      fill_cnt;

    btc_match #(.N(ENTRIES), .AW(ADDR_W), .IW(IW)) u_match (
        .valid (s_q.valid),
        .tags  (s_q.tag),
        .key   (br_target),
        .match (match_vec),
        .any   (any_match),
        .idx   (match_idx)
    );

    btc_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .valid     (s_q.valid),
        .victim    (victim_idx)
    );

    always_comb begin
        lookup    = br_valid && enable;
        touch     = lookup;
        touch_idx = any_match ? match_idx : victim_idx;
        fill_cnt  = s_q.cnt[s_q.fidx];

        hit       = lookup && any_match;
        hit_count = hit ? s_q.cnt[match_idx] : '0;
        hit_data  = hit ? s_q.data[match_idx] : '0;

        s_d = s_q;
        if (!enable) begin
            s_d.valid = '0;
            s_d.fst   = FILL_IDLE;
        end else if (br_valid) begin
            if (any_match) begin
                s_d.fst = FILL_IDLE;
            end else begin
                s_d.valid[victim_idx] = 1'b1;
                s_d.tag[victim_idx]   = br_target;
                s_d.cnt[victim_idx]   = '0;
                s_d.data[victim_idx]  = '0;
                s_d.fst               = FILL_BUSY;
                s_d.fidx              = victim_idx;
            end
        end else if (fill_valid && s_q.fst == FILL_BUSY) begin
            s_d.data[s_q.fidx][fill_cnt] = fill_byte;
            s_d.cnt[s_q.fidx]            = fill_cnt + CW'(1);
            if (fill_cnt == CW'(BYTES - 1)) s_d.fst = FILL_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.fst   <= FILL_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    disable_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (s_q.valid == '0));

    // R8
    no_hit_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !hit);

    // R6
    one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R3
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !br_valid && fill_valid && s_q.fst == FILL_BUSY)
        |=> (fill_cnt == $past(fill_cnt) + CW'(1)));

    // R5
    branch_ends_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && br_valid && any_match) |=> (s_q.fst == FILL_IDLE));

    for (genvar i = 0; i < ENTRIES; i++) begin : g_lim
        // R4
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s_q.cnt[i] <= CW'(BYTES));
    end
endmodule

// File: tb/branch_target_cache_tb.sv
module branch_target_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        br_valid = 1'b0;
    logic [15:0] br_target = '0;
    logic        fill_valid = 1'b0;
    logic [7:0]  fill_byte = '0;
    logic        hit;
    logic [2:0]  hit_count;
    logic [47:0] hit_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    branch_target_cache u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .br_valid(br_valid), .br_target(br_target),
        .fill_valid(fill_valid), .fill_byte(fill_byte),
        .hit(hit), .hit_count(hit_count), .hit_data(hit_data)
    );

    function automatic logic [7:0] pat(input logic [15:0] a, input int k);
        return a[7:0] ^ 8'(k * 17 + 3);
    endfunction

    function automatic logic [47:0] block(input logic [15:0] a, input int n);
        logic [47:0] v = '0;
        for (int k = 0; k < n; k++) v[8*k +: 8] = pat(a, k);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic branch(input logic [15:0] a, input logic with_fill,
                          output logic h, output logic [2:0] c, output logic [47:0] d);
        @(negedge clk);
        br_valid = 1'b1; br_target = a;
        fill_valid = with_fill; fill_byte = 8'hEE;
        #1;
        h = hit; c = hit_count; d = hit_data;
        @(posedge clk); #1;
        br_valid = 1'b0; fill_valid = 1'b0;
    endtask

    task automatic feed(input logic [15:0] a, input int first, input int n);
        for (int k = first; k < first + n; k++) begin
            @(negedge clk);
            fill_valid = 1'b1; fill_byte = pat(a, k);
            @(posedge clk); #1;
            fill_valid = 1'b0;
        end
    endtask

    task automatic expect_hit(input string req, input logic [15:0] a, input int n);
        logic h; logic [2:0] c; logic [47:0] d;
        branch(a, 1'b0, h, c, d);
        chk({req, " hit"}, 64'(h), 64'd1);
        chk({req, " count"}, 64'(c), 64'(n));
        chk({req, " data"}, 64'(d), 64'(block(a, n)));
    endtask

    task automatic expect_miss(input string req, input logic [15:0] a);
        logic h; logic [2:0] c; logic [47:0] d;
        branch(a, 1'b0, h, c, d);
        chk({req, " miss"}, 64'(h), 64'd0);
        chk({req, " miss outputs"}, {61'(d), c}, 64'd0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1 idle hit", 64'(hit), 64'd0);
        chk("R1 idle count/data", {61'(hit_data), hit_count}, 64'd0);
        expect_miss("R1 first branch", 16'h1000);
    endtask

    task automatic t_fill;
        feed(16'h1000, 0, 8);
        expect_hit("R3 R4 full block", 16'h1000, 6);
    endtask

    task automatic t_partial;
        expect_miss("R2 new target B", 16'h2234);
        feed(16'h2234, 0, 3);
        expect_miss("R5 interrupting target C", 16'h3456);
        feed(16'h3456, 0, 6);
        expect_hit("R5 R10 partial B", 16'h2234, 3);
        expect_hit("R2 C", 16'h3456, 6);
    endtask

    task automatic t_idle_fill;
        logic h; logic [2:0] c; logic [47:0] d;
        expect_hit("R9 B before", 16'h2234, 3);
        feed(16'h2234, 3, 2);
        expect_hit("R9 B after idle fill", 16'h2234, 3);
        branch(16'h4567, 1'b1, h, c, d);
        chk("R9 miss D with fill", 64'(h), 64'd0);
        feed(16'h4567, 0, 1);
        expect_hit("R9 D same-cycle fill ignored", 16'h4567, 1);
    endtask

    task automatic t_assoc;
        expect_hit("R6 A", 16'h1000, 6);
        expect_hit("R6 B", 16'h2234, 3);
        expect_hit("R6 C", 16'h3456, 6);
        expect_hit("R6 D", 16'h4567, 1);
    endtask

    task automatic t_lru;
        expect_miss("R7 fifth target E", 16'h5A5A);
        expect_hit("R7 B kept", 16'h2234, 3);
        expect_hit("R7 C kept", 16'h3456, 6);
        expect_hit("R7 D kept", 16'h4567, 1);
        expect_hit("R7 E stored", 16'h5A5A, 0);
        expect_miss("R7 A evicted", 16'h1000);
    endtask

    task automatic t_disable;
        logic h; logic [2:0] c; logic [47:0] d;
        @(negedge clk); enable = 1'b0;
        branch(16'h2234, 1'b0, h, c, d);
        chk("R8 no hit while off", 64'(h), 64'd0);
        @(negedge clk); enable = 1'b1;
        expect_miss("R8 B forgotten", 16'h2234);
        feed(16'h2234, 0, 2);
        expect_miss("R7 refill F", 16'h6001);
        expect_miss("R7 refill G", 16'h7002);
        expect_miss("R7 refill H", 16'h8003);
        expect_hit("R7 B after refill", 16'h2234, 2);
        expect_hit("R7 F after refill", 16'h6001, 0);
        expect_hit("R7 G after refill", 16'h7002, 0);
        expect_hit("R7 H after refill", 16'h8003, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill();
        t_partial();
        t_idle_fill();
        t_assoc();
        t_lru();
        t_disable();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #50000;
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule